// File: doc/BRIEF.md
# Dual-Table Register Renamer

This block maps the 8 architectural registers of an out-of-order core onto a 128-entry physical register file. It keeps two alias tables. The speculative table is read and written as operations are renamed. The committed table changes only when operations retire. Committed state is therefore a set of pointers into the physical file, and no value is ever copied into a separate architectural register file. A bitmap free list supplies new physical registers for destinations.

Each cycle, up to three operations arrive as a group in program order. Each lane carries two source registers and an optional destination. The block returns the physical tags for the sources, a new physical tag for each destination, and the tag that the destination replaced. That previous tag travels with the operation until it retires. In the same cycle, up to three retire events can each name an architectural register and the physical tag it now owns. Retirement moves the committed table forward and returns the tag it replaces to the free list. A flush throws away all speculative state by copying the committed table over the speculative one and rebuilding the free list from the committed table. Rename outputs are combinational from the current state, and all state changes take effect at the clock edge.

Top module: `dual_rat_rename`

## Requirements
- R1: After reset, architectural register i maps to physical tag i in both tables, and physical tags 8 to 127 are free.
- R2: When a group is accepted, each valid lane that has a destination receives a distinct free tag. The lowest-numbered free tags are handed out in lane order (lane 0 first). The source tags come from the speculative table, and the previous tag is the mapping the destination had before this lane.
- R3: Within a group, a source or destination in a later lane sees the tag allocated to an earlier lane's destination for the same architectural register. The latest earlier lane wins.
- R4: When the number of free tags is smaller than the number of valid lanes with a destination, ren_ok is 0 and neither table nor the free list changes. A group that needs no tags is accepted even when the free list is empty.
- R5: Each valid retire lane writes its tag into the committed table, and the tag it replaces returns to the free list. Lanes apply in order, so a later lane retiring the same register frees the tag written by the earlier lane.
- R6: While flush is 1, ren_ok is 0 and no rename takes effect. At the edge, the speculative table becomes a copy of the committed table, including retirements from the same cycle. The free list becomes every tag that the committed table does not reference.
- R7: A tag freed by retirement can be allocated no earlier than the cycle after the retirement.
- R8: A lane whose valid bit is 0, or whose destination flag is 0, consumes no tag and does not change the speculative table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restore speculative state from committed state |
| ren_valid | input | 3 | Per-lane rename request valid |
| ren_has_dst | input | 3 | Per-lane destination present |
| ren_src_a | input | 3x3 | Per-lane first source architectural register |
| ren_src_b | input | 3x3 | Per-lane second source architectural register |
| ren_dst | input | 3x3 | Per-lane destination architectural register |
| ret_valid | input | 3 | Per-lane retire event valid |
| ret_arch | input | 3x3 | Retiring architectural register |
| ret_tag | input | 3x7 | Physical tag now committed for that register |
| ren_ok | output | 1 | Group accepted this cycle |
| src_a_tag | output | 3x7 | Physical tag of first source |
| src_b_tag | output | 3x7 | Physical tag of second source |
| dst_tag | output | 3x7 | Newly allocated physical tag for the destination |
| prev_tag | output | 3x7 | Tag the destination mapped to before this lane |

## Verification
The stall path and the release path are the hard cases to reach, because both require the free list to be empty. The bench gets there by renaming full three-lane groups until exactly one tag remains. Then a two-tag group must stall, a one-tag group takes the last tag, and a tag-free group must still be accepted. From the empty state, a retirement that frees three tags is issued in the same cycle as a rename. That rename has to stall, and the three freed tags must come out in ascending order on the following cycle. The flush is issued together with a retirement, so the rebuilt tables show whether same-cycle retirements were included.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int DEF_ARCH  = 8;
    localparam int DEF_PHYS  = 128;
    localparam int DEF_LANES = 3;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int NUM_ARCH = rn_pkg::DEF_ARCH,
    parameter int NUM_PHYS = rn_pkg::DEF_PHYS,
    parameter int LANES    = rn_pkg::DEF_LANES,
    localparam int P_W     = $clog2(NUM_PHYS),
    localparam int C_W     = $clog2(NUM_PHYS + 1),
    localparam int L_W     = $clog2(LANES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_en,
    input  logic [L_W-1:0]                alloc_cnt,
    input  logic                          flush,
    input  logic [NUM_PHYS-1:0]           keep_mask,
    input  logic [NUM_PHYS-1:0]           release_mask,
    output logic [LANES-1:0][P_W-1:0]     pick,
    output logic [C_W-1:0]                free_cnt
);
    localparam logic [NUM_PHYS-1:0] RESET_FREE =
        ~((NUM_PHYS'(1) << NUM_ARCH) - NUM_PHYS'(1));

    typedef struct packed {
        logic [NUM_PHYS-1:0] free;
    } fl_state_t;

    fl_state_t st_d, st_q;

    always_comb begin
        logic [NUM_PHYS-1:0] scan;
        logic [NUM_PHYS-1:0] taken;
        logic                found;
        scan     = st_q.free;
        taken    = '0;
        free_cnt = '0;
        for (int i = 0; i < NUM_PHYS; i++) begin
            free_cnt = free_cnt + C_W'(st_q.free[i]);
        end
        for (int k = 0; k < LANES; k++) begin
            pick[k] = '0;
            found   = 1'b0;
            for (int i = 0; i < NUM_PHYS; i++) begin
                if (!found && scan[i]) begin
                    pick[k] = P_W'(i);
                    found   = 1'b1;
                end
            end
            if (found) begin
                scan[pick[k]] = 1'b0;
                if (k < int'(alloc_cnt)) begin
                    taken[pick[k]] = 1'b1;
                end
            end
        end
        st_d = st_q;
        if (flush) begin
            st_d.free = ~keep_mask;
        end else begin
            st_d.free = (st_q.free & ~(alloc_en ? taken : '0)) | release_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.free <= RESET_FREE;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: the top only allocates when enough tags are free
    a_r4_enough_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> free_cnt >= C_W'(alloc_cnt));

    // R6: after a rebuild exactly the unreferenced tags are free
    a_r6_rebuild_count: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> free_cnt == C_W'(NUM_PHYS - NUM_ARCH));
endmodule

// File: rtl/rn_retire_table.sv
module rn_retire_table #(
    parameter int NUM_ARCH = rn_pkg::DEF_ARCH,
    parameter int NUM_PHYS = rn_pkg::DEF_PHYS,
    parameter int LANES    = rn_pkg::DEF_LANES,
    localparam int A_W     = $clog2(NUM_ARCH),
    localparam int P_W     = $clog2(NUM_PHYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              ret_valid,
    input  logic [LANES-1:0][A_W-1:0]     ret_arch,
    input  logic [LANES-1:0][P_W-1:0]     ret_tag,
    output logic [NUM_ARCH-1:0][P_W-1:0]  rmap_next,
    output logic [NUM_PHYS-1:0]           release_mask,
    output logic [NUM_PHYS-1:0]           keep_mask
);
    typedef struct packed {
        logic [NUM_ARCH-1:0][P_W-1:0] rmap;
    } rt_state_t;

    rt_state_t st_d, st_q;

    always_comb begin
        logic [NUM_ARCH-1:0][P_W-1:0] walk;
        walk         = st_q.rmap;
        release_mask = '0;
        for (int k = 0; k < LANES; k++) begin
            if (ret_valid[k]) begin
                release_mask[walk[ret_arch[k]]] = 1'b1;
                walk[ret_arch[k]]               = ret_tag[k];
            end
        end
        keep_mask = '0;
        for (int a = 0; a < NUM_ARCH; a++) begin
            keep_mask[walk[a]] = 1'b1;
        end
        rmap_next = walk;
        st_d      = st_q;
        st_d.rmap = walk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < NUM_ARCH; a++) begin
                st_q.rmap[a] <= P_W'(a);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // R5: no more tags are released than retire lanes fire
    a_r5_release_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(release_mask) <= $countones(ret_valid));

    // R5: the last retire lane always lands in the committed table
    a_r5_last_lane_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid[LANES-1] |=>
            st_q.rmap[$past(ret_arch[LANES-1])] == $past(ret_tag[LANES-1]));
endmodule

// File: rtl/rn_front_table.sv
module rn_front_table #(
    parameter int NUM_ARCH = rn_pkg::DEF_ARCH,
    parameter int NUM_PHYS = rn_pkg::DEF_PHYS,
    parameter int LANES    = rn_pkg::DEF_LANES,
    localparam int A_W     = $clog2(NUM_ARCH),
    localparam int P_W     = $clog2(NUM_PHYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic                          flush,
    input  logic [LANES-1:0]              ren_valid,
    input  logic [LANES-1:0]              ren_has_dst,
    input  logic [LANES-1:0][A_W-1:0]     ren_src_a,
    input  logic [LANES-1:0][A_W-1:0]     ren_src_b,
    input  logic [LANES-1:0][A_W-1:0]     ren_dst,
    input  logic [LANES-1:0][P_W-1:0]     new_tag,
    input  logic [NUM_ARCH-1:0][P_W-1:0]  rmap_next,
    output logic [LANES-1:0][P_W-1:0]     src_a_tag,
    output logic [LANES-1:0][P_W-1:0]     src_b_tag,
    output logic [LANES-1:0][P_W-1:0]     prev_tag
);
    typedef struct packed {
        logic [NUM_ARCH-1:0][P_W-1:0] fmap;
    } ft_state_t;

    ft_state_t st_d, st_q;

    always_comb begin
        logic [NUM_ARCH-1:0][P_W-1:0] walk;
        walk = st_q.fmap;
        for (int k = 0; k < LANES; k++) begin
            src_a_tag[k] = walk[ren_src_a[k]];
            src_b_tag[k] = walk[ren_src_b[k]];
            prev_tag[k]  = walk[ren_dst[k]];
            if (ren_valid[k] && ren_has_dst[k]) begin
                walk[ren_dst[k]] = new_tag[k];
            end
        end
        st_d = st_q;
        if (flush) begin
            st_d.fmap = rmap_next;
        end else if (commit) begin
            st_d.fmap = walk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < NUM_ARCH; a++) begin
                st_q.fmap[a] <= P_W'(a);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a flush leaves the speculative table equal to committed state
    a_r6_flush_copy: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> st_q.fmap == $past(rmap_next));

    // R4: a refused group leaves the speculative table untouched
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !flush) |=> $stable(st_q.fmap));
endmodule

// File: rtl/dual_rat_rename.sv
module dual_rat_rename #(
    parameter int NUM_ARCH = rn_pkg::DEF_ARCH,
    parameter int NUM_PHYS = rn_pkg::DEF_PHYS,
    parameter int LANES    = rn_pkg::DEF_LANES,
    localparam int A_W     = $clog2(NUM_ARCH),
    localparam int P_W     = $clog2(NUM_PHYS),
    localparam int C_W     = $clog2(NUM_PHYS + 1),
    localparam int L_W     = $clog2(LANES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic [LANES-1:0]           ren_valid,
    input  logic [LANES-1:0]           ren_has_dst,
    input  logic [LANES-1:0][A_W-1:0]  ren_src_a,
    input  logic [LANES-1:0][A_W-1:0]  ren_src_b,
    input  logic [LANES-1:0][A_W-1:0]  ren_dst,
    input  logic [LANES-1:0]           ret_valid,
    input  logic [LANES-1:0][A_W-1:0]  ret_arch,
    input  logic [LANES-1:0][P_W-1:0]  ret_tag,
    output logic                       ren_ok,
    output logic [LANES-1:0][P_W-1:0]  src_a_tag,
    output logic [LANES-1:0][P_W-1:0]  src_b_tag,
    output logic [LANES-1:0][P_W-1:0]  dst_tag,
    output logic [LANES-1:0][P_W-1:0]  prev_tag
);
    logic [LANES-1:0][P_W-1:0]    pick;
    logic [C_W-1:0]               free_cnt;
    logic [L_W-1:0]               need;
    logic [NUM_ARCH-1:0][P_W-1:0] rmap_next;
    logic [NUM_PHYS-1:0]          release_mask;
    logic [NUM_PHYS-1:0]          keep_mask;

    always_comb begin
        need = '0;
        for (int k = 0; k < LANES; k++) begin
            dst_tag[k] = pick[need];
            if (ren_valid[k] && ren_has_dst[k]) begin
                need = need + L_W'(1);
            end
        end
        ren_ok = !flush && (free_cnt >= C_W'(need));
    end

    rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .LANES(LANES)) u_free (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_en     (ren_ok),
        .alloc_cnt    (need),
        .flush        (flush),
        .keep_mask    (keep_mask),
        .release_mask (release_mask),
        .pick         (pick),
        .free_cnt     (free_cnt)
    );

    rn_retire_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .LANES(LANES)) u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .ret_valid    (ret_valid),
        .ret_arch     (ret_arch),
        .ret_tag      (ret_tag),
        .rmap_next    (rmap_next),
        .release_mask (release_mask),
        .keep_mask    (keep_mask)
    );

    rn_front_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .LANES(LANES)) u_spec (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (ren_ok),
        .flush       (flush),
        .ren_valid   (ren_valid),
        .ren_has_dst (ren_has_dst),
        .ren_src_a   (ren_src_a),
        .ren_src_b   (ren_src_b),
        .ren_dst     (ren_dst),
        .new_tag     (dst_tag),
        .rmap_next   (rmap_next),
        .src_a_tag   (src_a_tag),
        .src_b_tag   (src_b_tag),
        .prev_tag    (prev_tag)
    );

    // R2: tags handed to two destination lanes in one group never collide
    a_r2_distinct_tags: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_ok && ren_valid[0] && ren_has_dst[0] && ren_valid[1] && ren_has_dst[1])
            |-> dst_tag[0] != dst_tag[1]);
endmodule

// File: tb/dual_rat_rename_test.sv
module dual_rat_rename_test;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush;
    logic [2:0]      ren_valid, ren_has_dst;
    logic [2:0][2:0] ren_src_a, ren_src_b, ren_dst;
    logic [2:0]      ret_valid;
    logic [2:0][2:0] ret_arch;
    logic [2:0][6:0] ret_tag;
    logic            ren_ok;
    logic [2:0][6:0] src_a_tag, src_b_tag, dst_tag, prev_tag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    dual_rat_rename uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ren_valid(ren_valid), .ren_has_dst(ren_has_dst),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .ret_valid(ret_valid), .ret_arch(ret_arch), .ret_tag(ret_tag),
        .ren_ok(ren_ok), .src_a_tag(src_a_tag), .src_b_tag(src_b_tag),
        .dst_tag(dst_tag), .prev_tag(prev_tag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        flush = 0; ren_valid = '0; ren_has_dst = '0;
        ren_src_a = '0; ren_src_b = '0; ren_dst = '0;
        ret_valid = '0; ret_arch = '0; ret_tag = '0;
    endtask

    task automatic lane(input int k, input bit v, input bit d, input int a, input int b, input int r);
        ren_valid[k] = v; ren_has_dst[k] = d;
        ren_src_a[k] = 3'(a); ren_src_b[k] = 3'(b); ren_dst[k] = 3'(r);
    endtask

    task automatic retire(input int k, input int r, input int t);
        ret_valid[k] = 1'b1; ret_arch[k] = 3'(r); ret_tag[k] = 7'(t);
    endtask

    task automatic begin_cycle();
        @(negedge clk);
        idle();
    endtask

    task automatic end_cycle();
        @(posedge clk);
    endtask

    // R1: identity mapping after reset, first free tag is 8
    task automatic t_reset_state();
        begin_cycle();
        lane(0, 1, 0, 0, 7, 0); lane(1, 1, 0, 2, 6, 0); lane(2, 1, 0, 4, 5, 0);
        #1;
        chk("R1", "ok", int'(ren_ok), 1);
        chk("R1", "l0 a", int'(src_a_tag[0]), 0);
        chk("R1", "l0 b", int'(src_b_tag[0]), 7);
        chk("R1", "l1 a", int'(src_a_tag[1]), 2);
        chk("R1", "l1 b", int'(src_b_tag[1]), 6);
        chk("R1", "l2 a", int'(src_a_tag[2]), 4);
        chk("R1", "l2 b", int'(src_b_tag[2]), 5);
        end_cycle();
    endtask

    // R2 and R3: allocation order and in-group forwarding
    task automatic t_group_forward();
        begin_cycle();
        lane(0, 1, 1, 1, 2, 1); lane(1, 1, 1, 1, 2, 2); lane(2, 1, 1, 1, 2, 1);
        #1;
        chk("R2", "ok", int'(ren_ok), 1);
        chk("R2", "l0 dst", int'(dst_tag[0]), 8);
        chk("R2", "l1 dst", int'(dst_tag[1]), 9);
        chk("R2", "l2 dst", int'(dst_tag[2]), 10);
        chk("R2", "l0 a", int'(src_a_tag[0]), 1);
        chk("R2", "l0 prev", int'(prev_tag[0]), 1);
        chk("R2", "l1 prev", int'(prev_tag[1]), 2);
        chk("R3", "l1 a fwd", int'(src_a_tag[1]), 8);
        chk("R3", "l1 b", int'(src_b_tag[1]), 2);
        chk("R3", "l2 a fwd", int'(src_a_tag[2]), 8);
        chk("R3", "l2 b fwd", int'(src_b_tag[2]), 9);
        chk("R3", "l2 prev fwd", int'(prev_tag[2]), 8);
        end_cycle();
    endtask

    // R8: invalid lane and no-destination lane consume nothing
    task automatic t_sparse_lanes();
        begin_cycle();
        lane(0, 1, 0, 1, 2, 5); lane(1, 0, 1, 0, 0, 6); lane(2, 1, 1, 3, 0, 3);
        #1;
        chk("R8", "ok", int'(ren_ok), 1);
        chk("R8", "l0 a", int'(src_a_tag[0]), 10);
        chk("R8", "l0 b", int'(src_b_tag[0]), 9);
        chk("R8", "l2 dst", int'(dst_tag[2]), 11);
        chk("R8", "l2 prev", int'(prev_tag[2]), 3);
        end_cycle();
        begin_cycle();
        lane(0, 1, 1, 5, 6, 4);
        #1;
        chk("R8", "next tag", int'(dst_tag[0]), 12);
        chk("R8", "r5 untouched", int'(src_a_tag[0]), 5);
        chk("R8", "r6 untouched", int'(src_b_tag[0]), 6);
        end_cycle();
    endtask

    // R4: drain the free list and stall on shortage
    task automatic t_exhaust_stall();
        for (int i = 0; i < 38; i++) begin
            begin_cycle();
            lane(0, 1, 1, 0, 0, 5); lane(1, 1, 1, 0, 0, 5); lane(2, 1, 1, 0, 0, 5);
            #1;
            chk("R4", "fill ok", int'(ren_ok), 1);
            chk("R2", "fill tag", int'(dst_tag[2]), 15 + 3 * i);
            end_cycle();
        end
        begin_cycle();
        lane(0, 1, 1, 0, 0, 6); lane(1, 1, 1, 0, 0, 6);
        #1;
        chk("R4", "stall two needed one free", int'(ren_ok), 0);
        end_cycle();
        begin_cycle();
        lane(0, 1, 1, 6, 5, 7);
        #1;
        chk("R4", "r6 unchanged by stall", int'(src_a_tag[0]), 6);
        chk("R4", "r5 last fill", int'(src_b_tag[0]), 126);
        chk("R4", "one fits", int'(ren_ok), 1);
        chk("R4", "last tag", int'(dst_tag[0]), 127);
        chk("R4", "last prev", int'(prev_tag[0]), 7);
        end_cycle();
        begin_cycle();
        lane(0, 1, 1, 0, 0, 6);
        #1;
        chk("R4", "empty stall", int'(ren_ok), 0);
        end_cycle();
        begin_cycle();
        lane(0, 1, 0, 7, 6, 0);
        #1;
        chk("R4", "no-dst accepted when empty", int'(ren_ok), 1);
        chk("R4", "r7 tag", int'(src_a_tag[0]), 127);
        chk("R4", "r6 still 6", int'(src_b_tag[0]), 6);
        end_cycle();
    endtask

    // R5 and R7: retirement frees replaced tags, usable next cycle
    task automatic t_retire_release();
        begin_cycle();
        retire(0, 1, 8); retire(1, 2, 9); retire(2, 1, 10);
        lane(0, 1, 1, 0, 0, 6);
        #1;
        chk("R7", "freed not yet usable", int'(ren_ok), 0);
        end_cycle();
        begin_cycle();
        lane(0, 1, 1, 0, 0, 0); lane(1, 1, 1, 0, 0, 0); lane(2, 1, 1, 0, 0, 0);
        #1;
        chk("R7", "usable next cycle", int'(ren_ok), 1);
        chk("R5", "freed 1", int'(dst_tag[0]), 1);
        chk("R5", "freed 2", int'(dst_tag[1]), 2);
        chk("R5", "freed 8 by later lane", int'(dst_tag[2]), 8);
        chk("R5", "prev chain", int'(prev_tag[2]), 2);
        end_cycle();
    endtask

    // R6: flush with a same-cycle retirement
    task automatic t_flush_restore();
        begin_cycle();
        flush = 1;
        retire(0, 3, 11);
        lane(0, 1, 0, 0, 0, 0);
        #1;
        chk("R6", "no rename during flush", int'(ren_ok), 0);
        end_cycle();
        begin_cycle();
        lane(0, 1, 0, 0, 3, 0); lane(1, 1, 0, 1, 4, 0); lane(2, 1, 0, 2, 7, 0);
        #1;
        chk("R6", "r0", int'(src_a_tag[0]), 0);
        chk("R6", "r3 same-cycle retire", int'(src_b_tag[0]), 11);
        chk("R6", "r1", int'(src_a_tag[1]), 10);
        chk("R6", "r4 spec discarded", int'(src_b_tag[1]), 4);
        chk("R6", "r2", int'(src_a_tag[2]), 9);
        chk("R6", "r7 spec discarded", int'(src_b_tag[2]), 7);
        end_cycle();
        begin_cycle();
        lane(0, 1, 1, 0, 0, 6); lane(1, 1, 1, 0, 0, 6); lane(2, 1, 1, 0, 0, 6);
        #1;
        chk("R6", "rebuilt ok", int'(ren_ok), 1);
        chk("R6", "rebuilt 1", int'(dst_tag[0]), 1);
        chk("R6", "rebuilt 2", int'(dst_tag[1]), 2);
        chk("R6", "rebuilt 3", int'(dst_tag[2]), 3);
        chk("R6", "prev r6", int'(prev_tag[0]), 6);
        end_cycle();
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_group_forward();
        t_sparse_lanes();
        t_exhaust_stall();
        t_retire_release();
        t_flush_restore();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule